// File: doc/BRIEF.md
# Masked Twiddle Index Generator

This block supplies the coefficient-table index for every butterfly of a constant-geometry radix-2 FFT of N = 2^LOG2N points. The coefficient table holds the N/2 values W^k, for k = 0 to N/2-1. The surrounding datapath runs two loop levels: stages, and butterflies within a stage. It never walks groups of butterflies that share a coefficient. Instead, the block keeps one pointer that steps once per butterfly. It ANDs that pointer with a mask chosen by the stage, and the result is the table index.

The mask keeps only the top s-1 bits of the (LOG2N-1)-bit pointer at stage s. Each later stage therefore uses twice the angular resolution of the one before. The first stage always sees index 0, and the last stage sees the unmasked pointer. A stage-start pulse loads the stage number and restarts the pointer. Each advance strobe yields one registered index, one cycle later, with a valid flag.

A level flag shows whether the current stage lets the two butterflies of an adjacent even/odd pair share one coefficient. This holds for every stage except the last, so the datapath may fetch once per pair in those stages.

Top module: `twiddle_mask_addr`

## Requirements
- R1: After reset tw_valid is 0, tw_idx is 0, and the stage is 1, so pair_shared reads 1.
- R2: A stage_start pulse loads the stage from stage_num and restarts the butterfly pointer b at 0. It does not raise tw_valid.
- R3: An advance strobe without stage_start makes tw_valid 1 for exactly the next cycle, with tw_idx holding the index for the current b, and then steps b. With no strobe, tw_valid is 0 and tw_idx holds its value.
- R4: At stage 1 every index is 0.
- R5: At stage 2 the first N/4 butterflies get index 0 and the rest get index N/4.
- R6: At any stage s from 1 to LOG2N, the index for butterfly b is (b >> (LOG2N-s)) << (LOG2N-s).
- R7: At stage LOG2N no masking applies: the index equals b, and pair_shared is 0.
- R8: At every stage below LOG2N, pair_shared is 1, and butterflies 2j and 2j+1 receive equal indices.
- R9: The pointer is LOG2N-1 bits wide and wraps to 0 after N/2 strobes.
- R10: An advance strobe in the same cycle as stage_start is ignored. The next strobe yields the index for b = 0.
- R11: A stage_num of 0 is taken as stage 1, and a stage_num above LOG2N is taken as stage LOG2N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stage_start | input | 1 | One-cycle pulse: load stage and restart pointer |
| stage_num | input | $clog2(LOG2N+1) | Stage number, counted from 1 |
| advance | input | 1 | One strobe per butterfly |
| tw_idx | output | LOG2N-1 | Registered coefficient-table index |
| tw_valid | output | 1 | tw_idx was updated by the previous strobe |
| pair_shared | output | 1 | Current stage lets an even/odd butterfly pair share one coefficient |

## Verification
A wrong pointer value appears on tw_idx one cycle after the next strobe in the last stage, where the mask passes every bit. In the earlier stages the same fault stays hidden until it reaches one of the kept upper bits. A mask that is wrong by one bit position breaks the stage-2 half split or the pair equality within a single stage's sweep. A missed pointer restart shows on the first index after stage_start. The bench therefore sweeps every stage completely, at two transform sizes, with restarts in mid-stage.

// File: rtl/twiddle_mask_addr.sv
module twiddle_mask_addr #(
  parameter int LOG2N = 4,
  localparam int IW = LOG2N - 1,
  localparam int SW = $clog2(LOG2N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stage_start,
  input  logic [SW-1:0] stage_num,
  input  logic          advance,
  output logic [IW-1:0] tw_idx,
  output logic          tw_valid,
  output logic          pair_shared
);

  logic [IW-1:0] ptr;
  logic [IW-1:0] mask;
  logic [SW-1:0] stage_q;
  logic [SW-1:0] stage_cl;
  logic          step;

  assign stage_cl = (stage_num == '0) ? SW'(1) :
                    (int'(stage_num) > LOG2N) ? SW'(LOG2N) : stage_num;
  assign step        = advance && !stage_start;
  assign pair_shared = (int'(stage_q) != LOG2N);

  for (genvar i = 0; i < IW; i++) begin : g_mask
    assign mask[i] = (int'(stage_q) + i >= LOG2N);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= SW'(1);
      ptr      <= '0;
      tw_idx   <= '0;
      tw_valid <= 1'b0;
    end else begin
      tw_valid <= step;
      if (stage_start) begin
        stage_q <= stage_cl;
        ptr     <= '0;
      end else if (advance) begin
        tw_idx <= ptr & mask;
        ptr    <= ptr + 1'b1;
      end
    end
  end

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> $past(advance && !stage_start)); // R3
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(advance && !stage_start) |-> $stable(tw_idx)); // R3
  AST_STAGE1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_valid && int'(stage_q) == 1 && !$past(stage_start)) |-> tw_idx == '0); // R4
  AST_PAIR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_valid && pair_shared && !$past(stage_start)) |-> !tw_idx[0]); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stage_start) |-> (ptr == '0)); // R2

endmodule

// File: tb/sim_twiddle_mask_addr.sv
`timescale 1ns/1ps
module sim_twiddle_mask_addr;
  logic clk = 0, rst_n = 0, start = 0, adv = 0;
  logic [2:0] stg0 = 3'd1, stg1 = 3'd1;
  logic [2:0] idx0;
  logic [4:0] idx1;
  logic v0, v1, ps0, ps1;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  twiddle_mask_addr #(.LOG2N(4)) u0 (.clk(clk), .rst_n(rst_n), .stage_start(start),
    .stage_num(stg0), .advance(adv), .tw_idx(idx0), .tw_valid(v0), .pair_shared(ps0));
  twiddle_mask_addr #(.LOG2N(6)) u1 (.clk(clk), .rst_n(rst_n), .stage_start(start),
    .stage_num(stg1), .advance(adv), .tw_idx(idx1), .tw_valid(v1), .pair_shared(ps1));

  function automatic int klog(int w); return w ? 6 : 4; endfunction
  function automatic int exp_idx(int k, int s, int b);
    int bb = b % (1 << (k - 1));
    return (bb >> (k - s)) << (k - s);
  endfunction
  function automatic int cur_idx(int w); return w ? int'(idx1) : int'(idx0); endfunction
  function automatic int cur_v(int w); return w ? int'(v1) : int'(v0); endfunction
  function automatic int cur_ps(int w); return w ? int'(ps1) : int'(ps0); endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_start(int w, int s, int s_eff, bit with_adv);
    @(negedge clk);
    if (w) stg1 = 3'(s); else stg0 = 3'(s);
    start = 1; adv = with_adv;
    @(negedge clk);
    start = 0; adv = 0;
    chk(cur_v(w) == 0, with_adv ? "R10" : "R2", cur_v(w), 0);
    chk(cur_ps(w) == int'(s_eff != klog(w)), "R8", cur_ps(w), int'(s_eff != klog(w)));
  endtask

  task automatic do_adv(int w, int s_eff, int b, string req);
    int gap = $urandom_range(0, 2);
    int held = cur_idx(w);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(cur_v(w) == 0 && cur_idx(w) == held, "R3", cur_v(w), 0);
    end
    adv = 1;
    @(negedge clk);
    adv = 0;
    chk(cur_v(w) == 1, "R3", cur_v(w), 1);
    chk(cur_idx(w) == exp_idx(klog(w), s_eff, b), req, cur_idx(w), exp_idx(klog(w), s_eff, b));
  endtask

  task automatic sweep(int w, int s, int s_eff, string req);
    int half = 1 << (klog(w) - 1);
    int prev = 0;
    do_start(w, s, s_eff, 0);
    for (int b = 0; b < half; b++) begin
      do_adv(w, s_eff, b, req);
      if (s_eff < klog(w) && (b % 2 == 1))
        chk(cur_idx(w) == prev, "R8", cur_idx(w), prev);
      prev = cur_idx(w);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(v0 == 0 && v1 == 0, "R1", int'(v0), 0);
    chk(idx0 == 0 && idx1 == 0, "R1", int'(idx0), 0);
    chk(ps0 == 1 && ps1 == 1, "R1", int'(ps0), 1);
    rst_n = 1;
    for (int w = 0; w < 2; w++) begin
      for (int s = 1; s <= klog(w); s++)
        sweep(w, s, s, s == 1 ? "R4" : s == 2 ? "R5" : s == klog(w) ? "R7" : "R6");
      do_adv(w, klog(w), 1 << (klog(w) - 1), "R9");
      do_adv(w, klog(w), (1 << (klog(w) - 1)) + 1, "R9");
      do_start(w, klog(w), klog(w), 0);
      for (int b = 0; b < 3; b++) do_adv(w, klog(w), b, "R7");
      do_start(w, klog(w), klog(w), 1);
      do_adv(w, klog(w), 0, "R10");
      do_adv(w, klog(w), 1, "R10");
      do_start(w, klog(w), klog(w), 0);
      do_adv(w, klog(w), 0, "R2");
      sweep(w, 0, 1, "R11");
      sweep(w, 7, klog(w), "R11");
      for (int r = 0; r < 6; r++) begin
        int s = $urandom_range(1, klog(w));
        int n = $urandom_range(1, 1 << (klog(w) - 1));
        do_start(w, s, s, 0);
        for (int b = 0; b < n; b++) do_adv(w, s, b, "R6");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule